// File: doc/BRIEF.md
# Predicated Vector Sub-Element Step Sequencer

This block walks the element loop of a vector instruction. It keeps three counters: a source element step, a destination element step and a sub-element step. Each accepted advance first moves the sub-element step through the sub-elements of the current element. When the sub-element step wraps, the source and destination steps move on. At that same wrap, each element step can jump forward over elements whose predicate bit is clear. The search for the next set bit is done in a single cycle and never goes past the vector length.

The sequencer also produces two status flags. One marks the last element and the other marks the end of the instruction, which is when a step reaches the vector length. It gives load and store offset multipliers built from the element step, the sub-vector length and the sub-step. An instruction with a zero vector length in vector mode is flagged to be skipped, and advance is then ignored. A loop-clear input restarts all three counters at zero.

Top module: `elem_step_seq`

## Requirements
- R1: An active-low asynchronous reset and a synchronous `loop_clr` both set `src_step`, `dst_step` and `sub_step` to 0. `loop_clr` wins over `advance` in the same cycle.
- R2: While `advance` and `loop_clr` are both low, all three steps keep their values.
- R3: On an accepted advance with `sub_step` below `subvl`, `sub_step` goes up by one and both element steps hold. `subvl` encodes the sub-element count minus one.
- R4: On an accepted advance with `sub_step` greater than or equal to `subvl`, `sub_step` returns to 0. Each element step goes up by one only if that gives a value below `vl`; otherwise it keeps its value as the candidate.
- R5: At a sub-step wrap, if the zeroing flag of a side is low and its candidate is below `vl`, that step becomes the lowest index i with candidate <= i < `vl` and mask bit i set (bit i of the mask belongs to element i). If no such bit exists it becomes `vl`. If the zeroing flag is high, the candidate is taken without a search. The source side uses `src_mask` and `src_zero`; the destination side uses `dst_mask` and `dst_zero`.
- R6: `done` is high when `vl` is nonzero and either element step equals `vl`.
- R7: `last_elem` is high when `vl` is nonzero and either element step equals `vl`-1.
- R8: `ld_offset` equals `src_step`*(`subvl`+1)+`sub_step` and `st_offset` equals `dst_step`*(`subvl`+1)+`sub_step`.
- R9: When `vec_mode` is high and `vl` is 0, `skip_insn` is high and `advance` changes no step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| vec_mode | input | 1 | Vector mode active |
| vl | input | 7 | Vector length |
| subvl | input | 2 | Sub-elements per element minus one |
| src_mask | input | 128 | Source predicate, bit i for element i |
| dst_mask | input | 128 | Destination predicate, bit i for element i |
| src_zero | input | 1 | Source zeroing: disables source skipping |
| dst_zero | input | 1 | Destination zeroing: disables destination skipping |
| advance | input | 1 | Step the loop once |
| loop_clr | input | 1 | Restart the loop at zero |
| src_step | output | 7 | Source element step |
| dst_step | output | 7 | Destination element step |
| sub_step | output | 2 | Sub-element step |
| last_elem | output | 1 | An element step is at vl-1 |
| done | output | 1 | An element step has reached vl |
| skip_insn | output | 1 | Zero-length vector instruction, skip it |
| ld_offset | output | 9 | Load offset multiplier |
| st_offset | output | 9 | Store offset multiplier |

## Verification
Two events can fall on the same edge. The first is the sub-step wrap, where the predicate search and the element increment resolve together. The second is a `loop_clr` or a zero-length skip arriving in the very cycle of an advance. The bench sets up both cases on purpose. It asserts `loop_clr` together with `advance` just as a wrap is due, and it drives advance while `vl` is 0 in vector mode. Random runs with sparse masks and every `subvl` value land many wraps on masked-off elements and on the `vl`-1 boundary. Each cycle, the steps, flags and offsets are compared against a loop model kept in the bench.

// File: rtl/esq_pkg.sv
package esq_pkg;
  localparam int unsigned ESQ_STEP_W = 7;
  localparam int unsigned ESQ_SUB_W  = 2;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_CLEAR = 2'd1,
    ACT_SUB   = 2'd2,
    ACT_WRAP  = 2'd3
  } esq_act_e;
endpackage

// File: rtl/esq_rst_sync.sv
module esq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/esq_ctrl.sv
module esq_ctrl
  import esq_pkg::*;
#(
  parameter int unsigned STEP_W = ESQ_STEP_W
) (
  input  logic              vec_mode,
  input  logic [STEP_W-1:0] vl,
  input  logic              advance,
  input  logic              loop_clr,
  input  logic              sub_at_end,
  output logic              skip_insn,
  output esq_act_e          act
);
  always_comb begin
    skip_insn = vec_mode && (vl == '0);
    if (loop_clr)                     act = ACT_CLEAR;
    else if (advance && !skip_insn)   act = sub_at_end ? ACT_WRAP : ACT_SUB;
    else                              act = ACT_HOLD;
  end
endmodule

// File: rtl/esq_sub_ctr.sv
module esq_sub_ctr
  import esq_pkg::*;
#(
  parameter int unsigned SUB_W = ESQ_SUB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  esq_act_e         act,
  input  logic [SUB_W-1:0] subvl,
  output logic [SUB_W-1:0] sub_step,
  output logic             sub_at_end
);
  logic [SUB_W-1:0] sub_d;
  logic             sub_en;

  always_comb begin
    sub_at_end = (sub_step >= subvl);
    sub_en     = (act != ACT_HOLD);
    unique case (act)
      ACT_SUB: sub_d = sub_step + 1'b1;
      default: sub_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sub_step <= '0;
    else if (sub_en) sub_step <= sub_d;
  end
endmodule

// File: rtl/esq_elem_ctr.sv
module esq_elem_ctr
  import esq_pkg::*;
#(
  parameter int unsigned STEP_W = ESQ_STEP_W,
  parameter int unsigned NELEM  = 1 << STEP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  esq_act_e          act,
  input  logic [STEP_W-1:0] vl,
  input  logic [NELEM-1:0]  mask,
  input  logic              zero,
  output logic [STEP_W-1:0] step
);
  logic [STEP_W:0]   inc_w;
  logic [STEP_W-1:0] base;
  logic [STEP_W-1:0] found;
  logic [STEP_W-1:0] seek;
  logic [STEP_W-1:0] step_d;
  logic              step_en;

  // candidate: one past the current step, unless that would reach vl
  always_comb begin
    inc_w = {1'b0, step} + 1'b1;
    base  = (inc_w < {1'b0, vl}) ? inc_w[STEP_W-1:0] : step;
  end

  // lowest set predicate bit in [base, vl), vl if none
  always_comb begin
    found = vl;
    for (int i = NELEM - 1; i >= 0; i--) begin
      if (mask[i] && (STEP_W'(i) >= base) && (STEP_W'(i) < vl))
        found = STEP_W'(i);
    end
  end

  always_comb begin
    seek    = (!zero && (base < vl)) ? found : base;
    step_en = (act == ACT_CLEAR) || (act == ACT_WRAP);
    unique case (act)
      ACT_CLEAR: step_d = '0;
      ACT_WRAP:  step_d = seek;
      default:   step_d = step;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       step <= '0;
    else if (step_en) step <= step_d;
  end
endmodule

// File: rtl/esq_offset.sv
module esq_offset #(
  parameter int unsigned STEP_W = 7,
  parameter int unsigned SUB_W  = 2,
  parameter int unsigned OFF_W  = STEP_W + SUB_W
) (
  input  logic [STEP_W-1:0] step,
  input  logic [SUB_W-1:0]  subvl,
  input  logic [SUB_W-1:0]  sub_step,
  output logic [OFF_W-1:0]  offset
);
  logic [OFF_W-1:0] per_elem;

  always_comb begin
    per_elem = OFF_W'(subvl) + 1'b1;
    offset   = (OFF_W'(step) * per_elem) + OFF_W'(sub_step);
  end
endmodule

// File: rtl/elem_step_seq.sv
module elem_step_seq
  import esq_pkg::*;
#(
  parameter int unsigned STEP_W = ESQ_STEP_W,
  parameter int unsigned SUB_W  = ESQ_SUB_W,
  localparam int unsigned NELEM = 1 << STEP_W,
  localparam int unsigned OFF_W = STEP_W + SUB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vec_mode,
  input  logic [STEP_W-1:0] vl,
  input  logic [SUB_W-1:0]  subvl,
  input  logic [NELEM-1:0]  src_mask,
  input  logic [NELEM-1:0]  dst_mask,
  input  logic              src_zero,
  input  logic              dst_zero,
  input  logic              advance,
  input  logic              loop_clr,
  output logic [STEP_W-1:0] src_step,
  output logic [STEP_W-1:0] dst_step,
  output logic [SUB_W-1:0]  sub_step,
  output logic              last_elem,
  output logic              done,
  output logic              skip_insn,
  output logic [OFF_W-1:0]  ld_offset,
  output logic [OFF_W-1:0]  st_offset
);
  logic              rst_sync_n;
  logic              sub_at_end;
  esq_act_e          act;
  logic [NELEM-1:0]  mask_a [2];
  logic              zero_a [2];
  logic [STEP_W-1:0] step_a [2];
  logic [OFF_W-1:0]  off_a  [2];
  logic [STEP_W-1:0] vl_m1;

  esq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  esq_ctrl #(.STEP_W(STEP_W)) u_ctrl (
    .vec_mode   (vec_mode),
    .vl         (vl),
    .advance    (advance),
    .loop_clr   (loop_clr),
    .sub_at_end (sub_at_end),
    .skip_insn  (skip_insn),
    .act        (act)
  );

  esq_sub_ctr #(.SUB_W(SUB_W)) u_sub (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .act        (act),
    .subvl      (subvl),
    .sub_step   (sub_step),
    .sub_at_end (sub_at_end)
  );

  // side 0 = source, side 1 = destination
  always_comb begin
    mask_a[0] = src_mask;
    mask_a[1] = dst_mask;
    zero_a[0] = src_zero;
    zero_a[1] = dst_zero;
  end

  for (genvar g = 0; g < 2; g++) begin : g_side
    esq_elem_ctr #(.STEP_W(STEP_W), .NELEM(NELEM)) u_elem (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .act   (act),
      .vl    (vl),
      .mask  (mask_a[g]),
      .zero  (zero_a[g]),
      .step  (step_a[g])
    );

    esq_offset #(.STEP_W(STEP_W), .SUB_W(SUB_W), .OFF_W(OFF_W)) u_off (
      .step     (step_a[g]),
      .subvl    (subvl),
      .sub_step (sub_step),
      .offset   (off_a[g])
    );
  end

  always_comb begin
    src_step  = step_a[0];
    dst_step  = step_a[1];
    ld_offset = off_a[0];
    st_offset = off_a[1];
    vl_m1     = vl - 1'b1;
    done      = (vl != '0) && ((src_step == vl) || (dst_step == vl));
    last_elem = (vl != '0) && ((src_step == vl_m1) || (dst_step == vl_m1));
  end
endmodule

// File: rtl/esq_chk.sv
module esq_chk #(
  parameter int unsigned STEP_W = 7,
  parameter int unsigned SUB_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              advance,
  input logic              loop_clr,
  input logic              skip_insn,
  input logic [SUB_W-1:0]  subvl,
  input logic [STEP_W-1:0] src_step,
  input logic [STEP_W-1:0] dst_step,
  input logic [SUB_W-1:0]  sub_step
);
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    loop_clr |=> (src_step == '0) && (dst_step == '0) && (sub_step == '0)); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !loop_clr) |=> $stable(src_step) && $stable(dst_step) && $stable(sub_step)); // R2

  AST_SUB_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !loop_clr && !skip_insn && (sub_step < subvl))
      |=> (sub_step == $past(sub_step) + 1'b1) && $stable(src_step) && $stable(dst_step)); // R3

  AST_WRAP_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !loop_clr && !skip_insn && (sub_step >= subvl))
      |=> (sub_step == '0) && (src_step >= $past(src_step)) && (dst_step >= $past(dst_step))); // R4

  AST_SKIP_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_insn && advance && !loop_clr)
      |=> $stable(src_step) && $stable(dst_step) && $stable(sub_step)); // R9
endmodule

bind elem_step_seq esq_chk #(.STEP_W(STEP_W), .SUB_W(SUB_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .advance   (advance),
  .loop_clr  (loop_clr),
  .skip_insn (skip_insn),
  .subvl     (subvl),
  .src_step  (src_step),
  .dst_step  (dst_step),
  .sub_step  (sub_step)
);

// File: tb/elem_step_seq_tb.sv
`timescale 1ns/1ps
module elem_step_seq_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         vec_mode;
  logic [6:0]   vl;
  logic [1:0]   subvl;
  logic [127:0] src_mask, dst_mask;
  logic         src_zero, dst_zero, advance, loop_clr;
  logic [6:0]   src_step, dst_step;
  logic [1:0]   sub_step;
  logic         last_elem, done, skip_insn;
  logic [8:0]   ld_offset, st_offset;

  int n_cmp = 0;
  int n_bad = 0;
  int m_src, m_dst, m_sub;
  bit finished = 0;

  always #2 clk = ~clk;

  elem_step_seq u_dut (
    .clk(clk), .rst_n(rst_n), .vec_mode(vec_mode), .vl(vl), .subvl(subvl),
    .src_mask(src_mask), .dst_mask(dst_mask), .src_zero(src_zero), .dst_zero(dst_zero),
    .advance(advance), .loop_clr(loop_clr), .src_step(src_step), .dst_step(dst_step),
    .sub_step(sub_step), .last_elem(last_elem), .done(done), .skip_insn(skip_insn),
    .ld_offset(ld_offset), .st_offset(st_offset)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // next element step per R4/R5
  function automatic int nxt(int s, int v, logic [127:0] m, bit z);
    int b = (s + 1 < v) ? s + 1 : s;
    int r;
    bit hit = 0;
    if (z || b >= v) return b;
    r = v;
    for (int i = b; i < v; i++)
      if (!hit && m[i]) begin r = i; hit = 1; end
    return r;
  endfunction

  task automatic model(bit adv, bit clr);
    if (clr) begin m_src = 0; m_dst = 0; m_sub = 0; end
    else if (adv && !(vec_mode && vl == 0)) begin
      if (m_sub >= int'(subvl)) begin
        m_sub = 0;
        m_src = nxt(m_src, int'(vl), src_mask, src_zero);
        m_dst = nxt(m_dst, int'(vl), dst_mask, dst_zero);
      end else m_sub = m_sub + 1;
    end
  endtask

  task automatic check_all(string req);
    int v = int'(vl);
    chk(req, "src_step", int'(src_step), m_src);
    chk(req, "dst_step", int'(dst_step), m_dst);
    chk(req, "sub_step", int'(sub_step), m_sub);
    chk("R6", "done", int'(done), int'(v != 0 && (m_src == v || m_dst == v)));
    chk("R7", "last_elem", int'(last_elem), int'(v != 0 && (m_src == v - 1 || m_dst == v - 1)));
    chk("R8", "ld_offset", int'(ld_offset), m_src * (int'(subvl) + 1) + m_sub);
    chk("R8", "st_offset", int'(st_offset), m_dst * (int'(subvl) + 1) + m_sub);
    chk("R9", "skip_insn", int'(skip_insn), int'(vec_mode && v == 0));
  endtask

  // called at a negedge; returns at the next negedge after the edge took effect
  task automatic tick(bit adv, bit clr, string req);
    advance = adv; loop_clr = clr;
    @(posedge clk);
    model(adv, clr);
    @(negedge clk);
    advance = 0; loop_clr = 0;
    check_all(req);
  endtask

  task automatic setup(int v, int sv, logic [127:0] sm, logic [127:0] dm, bit sz, bit dz);
    vl = 7'(v); subvl = 2'(sv); src_mask = sm; dst_mask = dm;
    src_zero = sz; dst_zero = dz;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    rst_n = 0; vec_mode = 1; advance = 0; loop_clr = 0;
    setup(5, 1, '1, '1, 0, 0);
    m_src = 0; m_dst = 0; m_sub = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check_all("R1");

    // R2: idle cycles hold
    tick(0, 0, "R2"); tick(0, 0, "R2");

    // R3/R4: full masks, subvl=1, vl=5: walk to the end and stay at vl-1
    for (int k = 0; k < 14; k++) tick(1, 0, (k % 2 == 0) ? "R3" : "R4");
    chk("R4", "src held at vl-1", int'(src_step), 4);

    // R1: clear together with advance at a due wrap
    chk("R1", "pre-clear sub", int'(sub_step), 0);
    tick(1, 0, "R3");
    tick(1, 1, "R1");
    chk("R1", "clear beats advance", int'(src_step), 0);

    // R5: sparse masks, subvl=0, vl=8: source bits 2,5; destination bit 7
    setup(8, 0, 128'h24, 128'h80, 0, 0);
    tick(0, 1, "R1");
    tick(1, 0, "R5");
    chk("R5", "src skip to 2", int'(src_step), 2);
    chk("R5", "dst skip to 7", int'(dst_step), 7);
    tick(1, 0, "R5");
    chk("R5", "src skip to 5", int'(src_step), 5);
    tick(1, 0, "R5");
    chk("R5", "src none left -> vl", int'(src_step), 8);
    chk("R6", "done at vl", int'(done), 1);
    tick(1, 0, "R6");

    // R5: zeroing disables the search
    setup(8, 0, 128'h0, 128'h0, 1, 1);
    tick(0, 1, "R1");
    tick(1, 0, "R5");
    chk("R5", "zeroing no skip", int'(src_step), 1);

    // R9: zero length in vector mode ignores advance; scalar mode does not skip
    setup(0, 2, '1, '1, 0, 0);
    tick(1, 0, "R9"); tick(1, 0, "R9");
    chk("R9", "sub unchanged", int'(sub_step), m_sub);
    vec_mode = 0;
    tick(1, 0, "R9"); tick(1, 0, "R3");
    vec_mode = 1;

    // random loops against the model
    for (int run = 0; run < 40; run++) begin
      setup(int'($urandom_range(127, 1)), int'($urandom_range(3, 0)),
            {$urandom, $urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom, $urandom},
            {$urandom, $urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom, $urandom},
            ($urandom_range(3, 0) == 0), ($urandom_range(3, 0) == 0));
      if (run % 8 == 7) begin src_mask = '0; dst_mask = '0; end
      tick(0, 1, "R1");
      for (int c = 0; c < 400 && !(done && m_src != 0 && $urandom_range(9, 0) == 0); c++)
        tick(($urandom_range(9, 0) < 8), ($urandom_range(99, 0) < 2), "R5");
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule